// File: doc/BRIEF.md
# Receiver Error Logger With Sample Hold

This block sits behind the frame decoder of a two-channel digital audio receiver. Each time a decoded sample is presented, the decoder also presents six error flags for that frame. The logger filters those flags through a per-bit enable mask. Enabled flags are recorded in a sticky status word that the host clears by reading it. Enabled flags also produce a one-clock error pulse and hold an interrupt level high.

The same enabled flags decide what happens to the sample. The host picks one of three policies:

- repeat the last delivered sample,
- mute the sample to zero,
- let the sample through untouched.

The two CRC flags, for the subcode and channel-status blocks, are logged and signalled like the others. They never alter audio, because they describe side data and not the sample itself.

All outputs are registered. A sample strobed in on one clock edge appears, processed, after that edge together with a one-cycle valid flag. The error pulse and the updated status appear at the same time.

Top module: `rx_err_logger`

## Requirements
- R1: After reset the status word, interrupt, error pulse, output sample and output valid are all zero.
- R2: Error flags count only in a cycle where the sample strobe is high. Bit positions are: 0 lock loss, 1 validity, 2 biphase, 3 parity, 4 subcode CRC, 5 channel-status CRC. An enabled flag sets its status bit, and the bit stays set until a read.
- R3: A read strobe clears every status bit at the following edge, except bits whose enabled error arrives in that same cycle; those bits remain set.
- R4: A flag whose mask bit is 0 sets no status bit, gives no pulse, raises no interrupt and leaves the sample untouched. A mask bit of 1 enables the flag.
- R5: A strobed frame carrying at least one enabled flag makes the error pulse high for exactly the one cycle after that edge.
- R6: The interrupt output is high exactly while any status bit is set.
- R7: With hold mode 2'b00, a frame hit by an enabled audio error (bits 0 to 3) delivers the previously delivered sample again. After reset that sample is zero.
- R8: With hold mode 2'b01, such a frame delivers zero.
- R9: With hold mode 2'b10 or 2'b11, such a frame delivers its own sample unchanged.
- R10: Enabled CRC flags (bits 4 and 5) never change the delivered sample, whatever the hold mode.
- R11: The processed sample and a one-cycle valid flag appear on the edge that follows the cycle in which the sample strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStb | input | 1 | Frame/sample present this cycle |
| sampleIn | input | 24 | Decoded audio sample |
| errIn | input | 6 | Error flags for the strobed frame |
| errMask | input | 6 | Per-flag enable, 1 = enabled |
| holdMode | input | 2 | Sample policy on audio error |
| rdStb | input | 1 | Host read of the status word |
| statusOut | output | 6 | Sticky error status |
| errPulse | output | 1 | One-cycle pulse per erroneous frame |
| irq | output | 1 | Interrupt level |
| sampleOut | output | 24 | Processed sample |
| sampleOutVld | output | 1 | Processed sample valid |

## Verification
Several properties are checked on every clock cycle:

- set bits survive while no read arrives;
- a read with no new error leaves the status empty;
- the interrupt tracks the status word;
- a frame with no enabled error gives no pulse and passes its sample untouched;
- zero-hold mutes any frame hit by an audio error.

Other behaviour needs history that only the directed scenarios build up:

- repeat-hold delivering the earlier sample;
- an error colliding with a read;
- reserved hold codes;
- flags without a strobe being ignored.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int ERR_N = 6;

  localparam int ERR_UNLOCK  = 0;
  localparam int ERR_VALID   = 1;
  localparam int ERR_BIPHASE = 2;
  localparam int ERR_PARITY  = 3;
  localparam int ERR_QCRC    = 4;
  localparam int ERR_CSCRC   = 5;

  // flags allowed to act on the audio sample
  localparam logic [ERR_N-1:0] AUDIO_ERR_SET =
    (ERR_N'(1) << ERR_UNLOCK) | (ERR_N'(1) << ERR_VALID) |
    (ERR_N'(1) << ERR_BIPHASE) | (ERR_N'(1) << ERR_PARITY);

  typedef enum logic [1:0] {
    HOLD_REPEAT = 2'b00,
    HOLD_ZERO   = 2'b01,
    HOLD_PASS   = 2'b10,
    HOLD_RSVD   = 2'b11
  } holdMode_t;

  typedef enum logic [1:0] {
    SEL_PASS   = 2'b00,
    SEL_REPEAT = 2'b01,
    SEL_ZERO   = 2'b10
  } sampleSel_t;

  typedef struct packed {
    logic [ERR_N-1:0] setBits;
    logic             clearAll;
    logic             loadSample;
    sampleSel_t       sel;
    logic             pulse;
  } ctrlStb_t;
endpackage

// File: rtl/rxerr_ctrl.sv
module rxerr_ctrl
  import rxerr_pkg::*;
(
  input  logic             sampleStb,
  input  logic [ERR_N-1:0] errIn,
  input  logic [ERR_N-1:0] errMask,
  input  logic [1:0]       holdMode,
  input  logic             rdStb,
  output ctrlStb_t         ctrl
);
  logic [ERR_N-1:0] enabledErr;
  logic             audioHit;

  always_comb begin
    enabledErr = sampleStb ? (errIn & errMask) : '0;
    audioHit   = |(enabledErr & AUDIO_ERR_SET);
  end

  always_comb begin
    ctrl            = '0;
    ctrl.setBits    = enabledErr;
    ctrl.clearAll   = rdStb;
    ctrl.loadSample = sampleStb;
    ctrl.pulse      = |enabledErr;
    ctrl.sel        = SEL_PASS;
    if (audioHit) begin
      unique case (holdMode_t'(holdMode))
        HOLD_REPEAT: ctrl.sel = SEL_REPEAT;
        HOLD_ZERO:   ctrl.sel = SEL_ZERO;
        default:     ctrl.sel = SEL_PASS;
      endcase
    end
  end
endmodule

// File: rtl/rxerr_datapath.sv
module rxerr_datapath
  import rxerr_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          ctrl,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [ERR_N-1:0]  statusQ,
  output logic              irqQ,
  output logic              pulseQ,
  output logic [DATA_W-1:0] sampleQ,
  output logic              sampleVldQ
);
  logic [ERR_N-1:0] statusNext;

  always_comb statusNext = ctrl.setBits | (ctrl.clearAll ? '0 : statusQ);

  for (genvar b = 0; b < ERR_N; b++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                statusQ[b] <= 1'b0;
      else if (ctrl.setBits[b]) statusQ[b] <= 1'b1;
      else if (ctrl.clearAll)   statusQ[b] <= 1'b0;
    end

    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[b] && !ctrl.clearAll) |=> statusQ[b])
      else $error("sticky bit %0d dropped without read", b);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ       <= 1'b0;
      pulseQ     <= 1'b0;
      sampleQ    <= '0;
      sampleVldQ <= 1'b0;
    end else begin
      irqQ       <= |statusNext;
      pulseQ     <= ctrl.pulse;
      sampleVldQ <= ctrl.loadSample;
      if (ctrl.loadSample) begin
        unique case (ctrl.sel)
          SEL_REPEAT: sampleQ <= sampleQ;
          SEL_ZERO:   sampleQ <= '0;
          default:    sampleQ <= sampleIn;
        endcase
      end
    end
  end

  p_read_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.clearAll && ctrl.setBits == '0) |=> (statusQ == '0))
    else $error("read did not clear status");

  p_vld_follow_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadSample |=> sampleVldQ)
    else $error("sample valid missing");
endmodule

// File: rtl/rx_err_logger.sv
module rx_err_logger
  import rxerr_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [ERR_N-1:0]  errIn,
  input  logic [ERR_N-1:0]  errMask,
  input  logic [1:0]        holdMode,
  input  logic              rdStb,
  output logic [ERR_N-1:0]  statusOut,
  output logic              errPulse,
  output logic              irq,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleOutVld
);
  ctrlStb_t ctrl;

  rxerr_ctrl u_ctrl (
    .sampleStb (sampleStb),
    .errIn     (errIn),
    .errMask   (errMask),
    .holdMode  (holdMode),
    .rdStb     (rdStb),
    .ctrl      (ctrl)
  );

  rxerr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .sampleIn   (sampleIn),
    .statusQ    (statusOut),
    .irqQ       (irq),
    .pulseQ     (errPulse),
    .sampleQ    (sampleOut),
    .sampleVldQ (sampleOutVld)
  );

  p_masked_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && (errIn & errMask) == '0 && !rdStb)
      |=> (!errPulse && statusOut == $past(statusOut)))
    else $error("masked frame had a visible effect");

  p_pulse_on_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && (errIn & errMask) != '0) |=> errPulse)
    else $error("no pulse for enabled error");

  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq == (|statusOut))
    else $error("interrupt does not track status");

  p_zero_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && (errIn & errMask & AUDIO_ERR_SET) != '0 && holdMode == 2'b01)
      |=> (sampleOut == '0))
    else $error("zero hold not applied");

  p_clean_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && (errIn & errMask & AUDIO_ERR_SET) == '0)
      |=> (sampleOut == $past(sampleIn)))
    else $error("sample altered without audio error");
endmodule

// File: tb/tb_rx_err_logger.sv
`timescale 1ns/1ps
module tb_rx_err_logger;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStb = 1'b0;
  logic [23:0] sampleIn = '0;
  logic [5:0]  errIn = '0;
  logic [5:0]  errMask = 6'h3F;
  logic [1:0]  holdMode = 2'b00;
  logic        rdStb = 1'b0;
  logic [5:0]  statusOut;
  logic        errPulse;
  logic        irq;
  logic [23:0] sampleOut;
  logic        sampleOutVld;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rx_err_logger dut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .sampleIn(sampleIn),
    .errIn(errIn), .errMask(errMask), .holdMode(holdMode), .rdStb(rdStb),
    .statusOut(statusOut), .errPulse(errPulse), .irq(irq),
    .sampleOut(sampleOut), .sampleOutVld(sampleOutVld)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one strobed frame; on return the registered results are visible
  task automatic frame(input logic [5:0] e, input logic [23:0] s, input logic rd);
    @(negedge clk);
    sampleStb = 1'b1; errIn = e; sampleIn = s; rdStb = rd;
    @(negedge clk);
    sampleStb = 1'b0; errIn = '0; rdStb = 1'b0;
  endtask

  task automatic hostRead();
    @(negedge clk);
    rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", 32'(statusOut), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pulse", 32'(errPulse), 0);
    chk("R1 sample", 32'(sampleOut), 0);
    chk("R1 vld", 32'(sampleOutVld), 0);
  endtask

  task automatic t_clean();
    errMask = 6'h3F; holdMode = 2'b01;
    frame(6'h00, 24'hA1A1A1, 1'b0);
    chk("R11 sample", 32'(sampleOut), 32'hA1A1A1);
    chk("R11 vld", 32'(sampleOutVld), 1);
    chk("R5 no pulse", 32'(errPulse), 0);
    @(negedge clk);
    chk("R11 vld one cycle", 32'(sampleOutVld), 0);
  endtask

  task automatic t_sticky();
    errMask = 6'h3F; holdMode = 2'b01;
    frame(6'h04, 24'hB2B2B2, 1'b0);
    chk("R8 zero", 32'(sampleOut), 0);
    chk("R5 pulse", 32'(errPulse), 1);
    chk("R2 status", 32'(statusOut), 32'h04);
    chk("R6 irq set", 32'(irq), 1);
    frame(6'h00, 24'hC3C3C3, 1'b0);
    chk("R5 pulse one cycle", 32'(errPulse), 0);
    chk("R2 sticky", 32'(statusOut), 32'h04);
    chk("R6 irq held", 32'(irq), 1);
    chk("R9 clean pass", 32'(sampleOut), 32'hC3C3C3);
  endtask

  task automatic t_nostrobe();
    @(negedge clk);
    errIn = 6'h08;
    @(negedge clk);
    errIn = '0;
    chk("R2 no strobe ignored", 32'(statusOut), 32'h04);
  endtask

  task automatic t_read();
    hostRead();
    chk("R3 cleared", 32'(statusOut), 0);
    chk("R6 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_collide();
    errMask = 6'h3F; holdMode = 2'b10;
    frame(6'h01, 24'h000001, 1'b0);
    chk("R2 bit0", 32'(statusOut), 32'h01);
    frame(6'h08, 24'h000002, 1'b1);
    chk("R3 collide kept", 32'(statusOut), 32'h08);
    chk("R6 irq collide", 32'(irq), 1);
    hostRead();
  endtask

  task automatic t_masked();
    errMask = 6'h3E; holdMode = 2'b01;
    frame(6'h01, 24'hD4D4D4, 1'b0);
    chk("R4 no log", 32'(statusOut), 0);
    chk("R4 no pulse", 32'(errPulse), 0);
    chk("R4 no irq", 32'(irq), 0);
    chk("R4 sample kept", 32'(sampleOut), 32'hD4D4D4);
    errMask = 6'h3F;
  endtask

  task automatic t_repeat();
    holdMode = 2'b00;
    frame(6'h00, 24'hE5E5E5, 1'b0);
    frame(6'h02, 24'hF6F6F6, 1'b0);
    chk("R7 repeat", 32'(sampleOut), 32'hE5E5E5);
    frame(6'h08, 24'h111111, 1'b0);
    chk("R7 repeat again", 32'(sampleOut), 32'hE5E5E5);
    hostRead();
  endtask

  task automatic t_pass();
    holdMode = 2'b10;
    frame(6'h08, 24'h123456, 1'b0);
    chk("R9 pass 10", 32'(sampleOut), 32'h123456);
    holdMode = 2'b11;
    frame(6'h04, 24'h654321, 1'b0);
    chk("R9 pass 11", 32'(sampleOut), 32'h654321);
    hostRead();
  endtask

  task automatic t_crc();
    holdMode = 2'b01;
    frame(6'h30, 24'h777777, 1'b0);
    chk("R10 crc untouched", 32'(sampleOut), 32'h777777);
    chk("R10 crc logged", 32'(statusOut), 32'h30);
    chk("R10 crc pulse", 32'(errPulse), 1);
    holdMode = 2'b00;
    frame(6'h10, 24'h888888, 1'b0);
    chk("R10 crc repeat mode", 32'(sampleOut), 32'h888888);
    hostRead();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_sticky();
    t_nostrobe();
    t_read();
    t_collide();
    t_masked();
    t_repeat();
    t_pass();
    t_crc();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule